// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 16-bit virtual byte addresses into physical addresses for a small core. Pages are 256 bytes, so the upper byte of an address is the virtual page number and the lower byte passes through untouched. Eight entries are searched in parallel on every lookup, and any page may sit in any entry. Each entry carries a valid flag, a dirty flag, read and write permission bits, a physical page number and a 3-bit age rank that keeps exact least-recently-used order.

A lookup that hits answers one cycle later. A lookup that misses raises a refill request that carries the page number. While the refill is pending, no new lookups are taken. The answer comes back over a valid-style completion: a physical page number with permissions, or a flag saying the page is absent. A filled page replaces the oldest entry. Loading a new page-table base value empties the whole buffer.

Top module: `xlat_buf`

## Requirements
- R1: A hit with the needed permission sets `rsp_valid` one cycle after the request is accepted. `rsp_pa` is the entry's physical page number in bits 15:8 and the request's address bits 7:0 in bits 7:0.
- R2: A request whose page number (address bits 15:8) matches no valid entry is a miss. In the cycle after acceptance, `fill_valid` is high, `fill_vpn` carries that page number, and `rsp_valid` stays low.
- R3: While a refill is pending, `req_ready` is low and `fill_vpn` holds steady. At all other times `req_ready` is high, except in a cycle where `ptb_load` is high.
- R4: A refill answer with `fill_absent` low installs the page, makes it valid, and returns `{fill_ppn, offset}` with `rsp_valid` in the cycle after `fill_done`.
- R5: Touching an entry of rank r sets its rank to 0. Every entry ranked below r moves up by one. Entries ranked above r keep their rank. A hit that passes the permission check and every install both count as a touch.
- R6: At reset all entries are invalid with rank 7. A refill replaces the lowest-indexed entry of rank 7.
- R7: A permitted write sets the entry's dirty flag, and a read leaves it as it was. `rsp_dirty` reports the entry's dirty flag after the access.
- R8: Permission bit 0 allows reads and bit 1 allows writes. A hit on an entry that forbids the operation sets `rsp_prot_fault` with `rsp_pa` = 0 and `rsp_dirty` = 0, and changes neither ranks nor dirty flags.
- R9: A refill whose permissions forbid the pending operation still installs the entry at rank 0, leaves it clean, and answers with `rsp_prot_fault`.
- R10: A refill answered with `fill_absent` high sets `rsp_page_fault` with `rsp_pa` = 0. It installs nothing and leaves all ranks unchanged.
- R11: A cycle with `ptb_load` high stores `ptb_value` into `ptb_q` for the next cycle. It invalidates every entry, returns every rank to 7, and blocks acceptance of a request in that cycle.
- R12: `rsp_valid` rises only in the cycle after an accepted request or a completed refill. It never shows both fault flags at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptb_load | input | 1 | Load a new page-table base value |
| ptb_value | input | 16 | Value to load |
| ptb_q | output | 16 | Current page-table base |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_va | input | 16 | Virtual byte address |
| req_wr | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 16 | Physical address (0 on a fault) |
| rsp_dirty | output | 1 | Dirty flag of the entry after the access |
| rsp_prot_fault | output | 1 | Permission denied |
| rsp_page_fault | output | 1 | Page not present |
| fill_valid | output | 1 | Refill requested |
| fill_vpn | output | 8 | Page number to refill |
| fill_done | input | 1 | Refill answer present |
| fill_ppn | input | 8 | Physical page number from refill |
| fill_perm | input | 2 | Permissions from refill (bit0 read, bit1 write) |
| fill_absent | input | 1 | Refill reports the page absent |

## Verification
The bench drives the block with long runs over a pool of pages a little larger than the buffer, so it sees evictions in every rank order. Every miss it predicts from its own age model must appear as a refill request. A wrong rank update or tie-break would evict the wrong page and turn a predicted hit into a refill, or the reverse. Directed cases cover a read-only page receiving a write and a write-only refill followed by a read. In those cases a design that changed state on a fault would show a set dirty flag or a shifted eviction later. An absent page that disturbed the ranks, or a base reload that left entries valid, would show up as hits where misses are expected.

// File: rtl/xb_pkg.sv
package xb_pkg;
  typedef enum logic [0:0] {ST_LOOK = 1'b0, ST_FILL = 1'b1} xb_state_e;

  localparam int unsigned PERM_W  = 2;
  localparam int unsigned PERM_RD = 0;
  localparam int unsigned PERM_WR = 1;

  // A write needs the write bit, a read needs the read bit.
  function automatic logic perm_allows(input logic [PERM_W-1:0] perm, input logic is_wr);
    return is_wr ? perm[PERM_WR] : perm[PERM_RD];
  endfunction
endpackage

// File: rtl/xb_match.sv
module xb_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned RANK_W = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]               key,
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  tags,
  input  logic [ENTRIES-1:0][RANK_W-1:0] ranks,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx,
  output logic [IDX_W-1:0]               victim_idx
);
  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] oldest;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g]  = valid[g] && (tags[g] == key);
    assign oldest[g] = (ranks[g] == OLDEST);
  end

  assign hit = |match;

  // Scan from the top so the lowest index wins.
  always_comb begin
    hit_idx    = '0;
    victim_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])  hit_idx    = IDX_W'(i);
      if (oldest[i]) victim_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xb_age.sv
module xb_age #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned RANK_W = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clear,
  input  logic                           touch,
  input  logic [IDX_W-1:0]               touch_idx,
  output logic [ENTRIES-1:0][RANK_W-1:0] ranks
);
  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ENTRIES - 1);

  logic [RANK_W-1:0] ref_rank;
  assign ref_rank = ranks[touch_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
    logic [RANK_W-1:0] rank_q;
    logic              is_tgt;
    assign is_tgt   = touch && (touch_idx == IDX_W'(g));
    assign ranks[g] = rank_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        rank_q <= OLDEST;
      end else if (clear) begin
        rank_q <= is_tgt ? '0 : OLDEST;
      end else if (touch) begin
        if (is_tgt)
          rank_q <= '0;
        else if (rank_q < ref_rank)
          rank_q <= rank_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xb_store.sv
module xb_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 8,
  parameter int unsigned PPN_W   = 8,
  parameter int unsigned PERM_W  = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clear,
  input  logic                           ins_en,
  input  logic [IDX_W-1:0]               ins_idx,
  input  logic [VPN_W-1:0]               ins_vpn,
  input  logic [PPN_W-1:0]               ins_ppn,
  input  logic [PERM_W-1:0]              ins_perm,
  input  logic                           ins_dirty,
  input  logic                           dirty_set,
  input  logic [IDX_W-1:0]               dirty_idx,
  input  logic                           rd_en,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [PPN_W-1:0]               rd_ppn,
  output logic [ENTRIES-1:0]             valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]  tags,
  output logic [ENTRIES-1:0][PERM_W-1:0] perms,
  output logic [ENTRIES-1:0]             dirty
);
  // Physical page numbers: one write port, one registered read port.
  logic [PPN_W-1:0] ppn_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (ins_en) ppn_mem[ins_idx] <= ins_ppn;
    if (rd_en)  rd_ppn <= ppn_mem[rd_idx];
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              v_q;
    logic              d_q;
    logic [VPN_W-1:0]  t_q;
    logic [PERM_W-1:0] p_q;
    logic              ins_here;
    assign ins_here = ins_en && (ins_idx == IDX_W'(g));
    assign valid[g] = v_q;
    assign dirty[g] = d_q;
    assign tags[g]  = t_q;
    assign perms[g] = p_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
        p_q <= '0;
      end else begin
        if (ins_here)   v_q <= 1'b1;
        else if (clear) v_q <= 1'b0;
        if (ins_here) begin
          d_q <= ins_dirty;
          t_q <= ins_vpn;
          p_q <= ins_perm;
        end else if (dirty_set && (dirty_idx == IDX_W'(g))) begin
          d_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xb_pkg::*;
#(
  parameter int unsigned VA_W    = 16,
  parameter int unsigned PA_W    = 16,
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PTB_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ptb_load,
  input  logic [PTB_W-1:0]         ptb_value,
  output logic [PTB_W-1:0]         ptb_q,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_va,
  input  logic                     req_wr,
  output logic                     rsp_valid,
  output logic [PA_W-1:0]          rsp_pa,
  output logic                     rsp_dirty,
  output logic                     rsp_prot_fault,
  output logic                     rsp_page_fault,
  output logic                     fill_valid,
  output logic [VA_W-OFS_W-1:0]    fill_vpn,
  input  logic                     fill_done,
  input  logic [PA_W-OFS_W-1:0]    fill_ppn,
  input  logic [PERM_W-1:0]        fill_perm,
  input  logic                     fill_absent
);
  localparam int unsigned VPN_W  = VA_W - OFS_W;
  localparam int unsigned PPN_W  = PA_W - OFS_W;
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned RANK_W = $clog2(ENTRIES);

  xb_state_e state_q;

  logic [VPN_W-1:0] req_vpn;
  logic [VPN_W-1:0] vpn_q;
  logic [OFS_W-1:0] off_q;
  logic             wr_q;

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0]             ent_dirty;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_tag;
  logic [ENTRIES-1:0][PERM_W-1:0] ent_perm;
  logic [ENTRIES-1:0][RANK_W-1:0] ranks;
  logic [PPN_W-1:0]               mem_ppn;

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] victim_idx;
  logic             hit_ok;
  logic             fill_ok;
  logic             accept;
  logic             look_hit_ok;
  logic             install;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;

  logic             rsp_valid_q;
  logic             rsp_mem_q;
  logic [PPN_W-1:0] rsp_ppn_q;
  logic             rsp_dirty_q;
  logic             rsp_prot_q;
  logic             rsp_pf_q;

  assign req_vpn     = req_va[VA_W-1:OFS_W];
  assign req_ready   = (state_q == ST_LOOK) && !ptb_load;
  assign accept      = req_valid && req_ready;
  assign hit_ok      = perm_allows(ent_perm[hit_idx], req_wr);
  assign fill_ok     = perm_allows(fill_perm, wr_q);
  assign look_hit_ok = accept && hit && hit_ok;
  assign install     = (state_q == ST_FILL) && fill_done && !fill_absent;
  assign touch       = look_hit_ok || install;
  assign touch_idx   = (state_q == ST_FILL) ? victim_idx : hit_idx;

  xb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .key        (req_vpn),
    .valid      (ent_valid),
    .tags       (ent_tag),
    .ranks      (ranks),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .victim_idx (victim_idx)
  );

  xb_age #(.ENTRIES(ENTRIES)) u_age (
    .clk       (clk),
    .rst       (rst),
    .clear     (ptb_load),
    .touch     (touch),
    .touch_idx (touch_idx),
    .ranks     (ranks)
  );

  xb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .clear     (ptb_load),
    .ins_en    (install),
    .ins_idx   (victim_idx),
    .ins_vpn   (vpn_q),
    .ins_ppn   (fill_ppn),
    .ins_perm  (fill_perm),
    .ins_dirty (fill_ok && wr_q),
    .dirty_set (look_hit_ok && req_wr),
    .dirty_idx (hit_idx),
    .rd_en     (look_hit_ok),
    .rd_idx    (hit_idx),
    .rd_ppn    (mem_ppn),
    .valid     (ent_valid),
    .tags      (ent_tag),
    .perms     (ent_perm),
    .dirty     (ent_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) ptb_q <= '0;
    else if (ptb_load) ptb_q <= ptb_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_LOOK;
      vpn_q       <= '0;
      off_q       <= '0;
      wr_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_mem_q   <= 1'b0;
      rsp_ppn_q   <= '0;
      rsp_dirty_q <= 1'b0;
      rsp_prot_q  <= 1'b0;
      rsp_pf_q    <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_LOOK: begin
          if (accept) begin
            off_q <= req_va[OFS_W-1:0];
            if (hit) begin
              rsp_valid_q <= 1'b1;
              rsp_mem_q   <= hit_ok;
              rsp_ppn_q   <= '0;
              rsp_dirty_q <= hit_ok && (ent_dirty[hit_idx] || req_wr);
              rsp_prot_q  <= !hit_ok;
              rsp_pf_q    <= 1'b0;
            end else begin
              vpn_q   <= req_vpn;
              wr_q    <= req_wr;
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (fill_done) begin
            state_q     <= ST_LOOK;
            rsp_valid_q <= 1'b1;
            rsp_mem_q   <= 1'b0;
            if (fill_absent) begin
              rsp_ppn_q   <= '0;
              rsp_dirty_q <= 1'b0;
              rsp_prot_q  <= 1'b0;
              rsp_pf_q    <= 1'b1;
            end else begin
              rsp_ppn_q   <= fill_ok ? fill_ppn : '0;
              rsp_dirty_q <= fill_ok && wr_q;
              rsp_prot_q  <= !fill_ok;
              rsp_pf_q    <= 1'b0;
            end
          end
        end
        default: state_q <= ST_LOOK;
      endcase
    end
  end

  assign rsp_valid      = rsp_valid_q;
  assign rsp_dirty      = rsp_dirty_q;
  assign rsp_prot_fault = rsp_prot_q;
  assign rsp_page_fault = rsp_pf_q;
  assign rsp_pa         = (rsp_prot_q || rsp_pf_q) ? '0 :
                          rsp_mem_q ? {mem_ppn, off_q} : {rsp_ppn_q, off_q};
  assign fill_valid     = (state_q == ST_FILL);
  assign fill_vpn       = vpn_q;
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned PTB_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ptb_load,
  input logic [PTB_W-1:0] ptb_value,
  input logic [PTB_W-1:0] ptb_q,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             rsp_dirty,
  input logic             rsp_prot_fault,
  input logic             rsp_page_fault,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic             fill_done,
  input logic             fill_absent
);
  AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid || fill_valid)); // R2
  AST_NO_ACCEPT_IN_FILL: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !req_ready); // R3
  AST_FILL_KEY_HELD: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !fill_done) |=> (fill_valid && $stable(fill_vpn))); // R3
  AST_FILL_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_done) |=> (rsp_valid && !fill_valid)); // R4
  AST_FAULT_BLANK: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_prot_fault || rsp_page_fault)) |-> (rsp_pa == '0 && !rsp_dirty)); // R8
  AST_ABSENT_FAULT: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_done && fill_absent) |=> rsp_page_fault); // R10
  AST_BASE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    ptb_load |=> (ptb_q == $past(ptb_value))); // R11
  AST_BASE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    ptb_load |-> !req_ready); // R11
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_prot_fault && rsp_page_fault)); // R12
  AST_RSP_CAUSED: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> ($past(req_valid && req_ready) || $past(fill_valid && fill_done))); // R12
endmodule

bind xlat_buf xlat_buf_chk #(
  .VPN_W(VA_W - OFS_W), .PA_W(PA_W), .PTB_W(PTB_W)
) u_chk (.*);

// File: tb/xlat_buf_bench.sv
`timescale 1ns/1ps
module xlat_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptb_load = 1'b0;
  logic [15:0] ptb_value = '0;
  logic [15:0] ptb_q;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_va = '0;
  logic        req_wr = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_pa;
  logic        rsp_dirty;
  logic        rsp_prot_fault;
  logic        rsp_page_fault;
  logic        fill_valid;
  logic [7:0]  fill_vpn;
  logic        fill_done = 1'b0;
  logic [7:0]  fill_ppn = '0;
  logic [1:0]  fill_perm = '0;
  logic        fill_absent = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xlat_buf u_xlat_buf (.*);

  // Reference state built from the requirements.
  bit         m_vld   [8];
  logic [7:0] m_vpn   [8];
  logic [7:0] m_ppn   [8];
  logic [1:0] m_perm  [8];
  bit         m_dirty [8];
  int         m_rank  [8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [7:0] vpn);
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < 8; i++) if (m_rank[i] == 7) return i;
    return 0;
  endfunction

  function automatic void m_touch(input int idx);
    int r;
    r = m_rank[idx];
    for (int i = 0; i < 8; i++) begin
      if (i == idx) m_rank[i] = 0;
      else if (m_rank[i] < r) m_rank[i] = m_rank[i] + 1;
    end
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 0; m_rank[i] = 7; m_dirty[i] = 0;
    end
  endfunction

  task automatic access(input logic [7:0] vpn, input logic [7:0] off, input bit wr,
                        input bit absent, input logic [7:0] new_ppn, input logic [1:0] new_perm,
                        input int wait_cyc);
    int idx;
    bit ok;
    logic [18:0] exp_r;
    logic [18:0] act_r;
    idx = m_find(vpn);
    @(negedge clk);
    req_valid = 1'b1; req_va = {vpn, off}; req_wr = wr;
    #1 chk(req_ready === 1'b1, "R3 ready while idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (idx >= 0) begin
      ok = m_perm[idx][wr];
      if (ok) begin
        m_dirty[idx] = m_dirty[idx] | wr;
        exp_r = {m_ppn[idx], off, m_dirty[idx], 1'b0, 1'b0};
        m_touch(idx);
      end else begin
        exp_r = {16'h0, 1'b0, 1'b1, 1'b0};
      end
      act_r = {rsp_pa, rsp_dirty, rsp_prot_fault, rsp_page_fault};
      chk(rsp_valid === 1'b1 && fill_valid === 1'b0 && act_r === exp_r,
          "R1 R5 R7 R8 R12 hit response", {13'd0, act_r}, {13'd0, exp_r});
    end else begin
      chk(fill_valid === 1'b1 && rsp_valid === 1'b0 && fill_vpn === vpn,
          "R2 R5 R6 miss request", {23'd0, fill_valid, fill_vpn}, {23'd1, vpn});
      for (int k = 0; k < wait_cyc; k++) begin
        @(negedge clk);
        chk(fill_valid === 1'b1 && req_ready === 1'b0 && fill_vpn === vpn,
            "R3 pending refill", {22'd0, fill_valid, req_ready, fill_vpn}, {22'd2, vpn});
      end
      fill_done = 1'b1; fill_ppn = new_ppn; fill_perm = new_perm; fill_absent = absent;
      @(negedge clk);
      fill_done = 1'b0;
      act_r = {rsp_pa, rsp_dirty, rsp_prot_fault, rsp_page_fault};
      if (absent) begin
        exp_r = {16'h0, 1'b0, 1'b0, 1'b1};
        chk(rsp_valid === 1'b1 && act_r === exp_r, "R10 absent page",
            {13'd0, act_r}, {13'd0, exp_r});
      end else begin
        idx = m_victim();
        ok = new_perm[wr];
        m_vld[idx] = 1; m_vpn[idx] = vpn; m_ppn[idx] = new_ppn;
        m_perm[idx] = new_perm; m_dirty[idx] = ok & wr;
        m_touch(idx);
        exp_r = ok ? {new_ppn, off, m_dirty[idx], 1'b0, 1'b0} : {16'h0, 1'b0, 1'b1, 1'b0};
        chk(rsp_valid === 1'b1 && fill_valid === 1'b0 && act_r === exp_r,
            ok ? "R4 R7 refill response" : "R9 forbidden refill",
            {13'd0, act_r}, {13'd0, exp_r});
      end
    end
  endtask

  task automatic load_base(input logic [15:0] val);
    @(negedge clk);
    ptb_load = 1'b1; ptb_value = val;
    #1 chk(req_ready === 1'b0, "R11 ready blocked on base load", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    ptb_load = 1'b0;
    chk(ptb_q === val, "R11 base value", {16'd0, ptb_q}, {16'd0, val});
    m_reset();
  endtask

  initial begin
    logic [7:0] v;
    logic [1:0] p;
    int sel;
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && fill_valid === 1'b0 && rsp_valid === 1'b0 && ptb_q === 16'h0,
        "R6 reset state", {13'd0, req_ready, fill_valid, rsp_valid, ptb_q}, {13'd4, 16'h0});

    // Fill all eight entries, then wrap around: rank order drives eviction (R5, R6).
    for (int i = 0; i < 8; i++) access(8'h10 + 8'(i), 8'(i * 3), i[0], 0, 8'h80 + 8'(i), 2'b11, i % 3);
    access(8'h12, 8'hf0, 1'b0, 0, 8'h00, 2'b11, 0);  // hit, rank shuffle
    access(8'h12, 8'h0f, 1'b0, 0, 8'h00, 2'b11, 0);  // R7 read keeps dirty clear
    access(8'h13, 8'h01, 1'b0, 0, 8'h00, 2'b11, 0);  // R7 dirty reported after earlier write
    access(8'h20, 8'h55, 1'b1, 0, 8'h90, 2'b11, 1);  // evicts oldest
    access(8'h10, 8'h00, 1'b0, 0, 8'h91, 2'b11, 0);  // must miss again
    // R8: read-only page written, then read; nothing changes.
    access(8'h30, 8'h44, 1'b0, 0, 8'ha0, 2'b01, 0);
    access(8'h30, 8'h45, 1'b1, 0, 8'h00, 2'b11, 0);
    access(8'h30, 8'h46, 1'b0, 0, 8'h00, 2'b11, 0);
    // R9: write-only refill on a read.
    access(8'h31, 8'h07, 1'b0, 0, 8'ha1, 2'b10, 2);
    access(8'h31, 8'h08, 1'b1, 0, 8'h00, 2'b11, 0);
    // R10: absent page, then a normal miss shows ranks untouched.
    access(8'h32, 8'h09, 1'b1, 1, 8'h00, 2'b11, 1);
    access(8'h33, 8'h0a, 1'b0, 0, 8'ha3, 2'b11, 0);
    // R11: reload empties the buffer.
    load_base(16'hbeef);
    access(8'h30, 8'h11, 1'b0, 0, 8'hb0, 2'b11, 0);
    access(8'h30, 8'h12, 1'b0, 0, 8'h00, 2'b11, 0);

    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 49) == 0) load_base(16'($urandom()));
      v = 8'h40 + 8'($urandom_range(0, 13));
      sel = $urandom_range(0, 9);
      p = (sel < 7) ? 2'b11 : (sel == 7) ? 2'b01 : (sel == 8) ? 2'b10 : 2'b00;
      access(v, 8'($urandom()), 1'($urandom()), $urandom_range(0, 11) == 0,
             8'($urandom()), p, $urandom_range(0, 2));
    end

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule